// File: doc/BRIEF.md
# Dual-Strobe Decimal Up/Down Counter

This block holds one decimal digit (states 0 to 9) and steps it with two separate strobes: a rising edge on the up strobe adds one, and a rising edge on the down strobe takes one away. Both strobes are ordinary inputs that are sampled on a single free-running system clock. Each one passes through a two-flop synchronizer, and a count event is a detected rising edge of the synchronized level. A count event is accepted only while the opposite strobe is high, so the strobe that is not in use must idle high.

A master reset input, active high, clears the digit and takes priority over everything else. An active-low load input copies a 4-bit value into the digit and takes priority over the strobes. Two active-low outputs mark the ends of the range. The carry output follows the up strobe's low phase while the digit reads 9. The borrow output follows the down strobe's low phase while the digit reads 0. Because these outputs copy the strobe waveform, they can feed the strobes of the next digit, so several instances on the same system clock form a multi-digit counter. A loaded value from 10 to 15 is legal. From any of those states the next up step gives 0 and the next down step gives 9.

Top module: `bcd_dual_strobe_counter`

## Requirements
- R1: Once the digit holds a value from 0 to 9, stepping never takes it out of that range. Only a load can produce a value from 10 to 15.
- R2: A rising edge of the up strobe, seen while the down strobe is high, adds one to the digit. 9 steps to 0. The digit changes on the third system clock edge after the strobe input rises, counting the two synchronizer flops.
- R3: A rising edge of the down strobe, seen while the up strobe is high, subtracts one from the digit. 0 steps to 9.
- R4: A rising edge of one strobe while the other strobe is low does not change the digit. With both strobes held steady, the digit holds.
- R5: The system reset `rst_n` is synchronous and active low. While it is low, the digit is 0 and carry_n and borrow_n are high.
- R6: While master_reset is 1, the digit reads 0 one clock after it is sampled, whatever load_n and the strobes do.
- R7: While master_reset is 0 and load_n is 0, the digit takes load_value one clock after it is sampled, whatever the strobes do.
- R8: carry_n is 0 only while the digit is 9 and the synchronized up strobe is 0. Otherwise it is 1.
- R9: borrow_n is 0 only while the digit is 0 and the synchronized down strobe is 0. Otherwise it is 1.
- R10: If a strobe is low during a master reset or a load and stays low after it ends, its next rising edge counts as a normal step.
- R11: From a loaded value of 10 to 15, an up step gives 0 and a down step gives 9. While the digit is in that range, carry_n and borrow_n stay 1.
- R12: If both synchronized strobes rise on the same clock, the digit does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Synchronous system reset, active low |
| up_strobe | input | 1 | Up step strobe; its rising edge counts |
| down_strobe | input | 1 | Down step strobe; its rising edge counts |
| master_reset | input | 1 | Clears the digit, active high, top priority |
| load_n | input | 1 | Copies load_value into the digit, active low |
| load_value | input | 4 | Value to load |
| count | output | 4 | Current digit |
| carry_n | output | 1 | Active-low terminal output for up counting |
| borrow_n | output | 1 | Active-low terminal output for down counting |

## Verification
A wrong digit shows directly on `count` on the clock after the step, load or reset that caused it, because the digit is driven straight from its register. A fault in a synchronizer stage or in the edge detector shows a different way: the step lands a cycle early or late, or it is counted twice or missed. For that reason, each count check samples a fixed number of cycles after the strobe is driven. Faults in terminal detection or in the strobe gating show on carry_n and borrow_n two cycles after the strobe falls, and they matter most at 9, at 0 and in the range 10 to 15.

// File: rtl/bcd_counter_pkg.sv
// Shared widths and helper functions for the dual-strobe decimal counter.
package bcd_counter_pkg;
    localparam int DIGIT_W = 4;
    localparam int MODULUS = 10;
    typedef logic [DIGIT_W-1:0] digit_t;

    // Next value for an up step. Any value at or above the top wraps to 0.
    function automatic digit_t step_up(input digit_t v, input int unsigned modulus);
        if (int'(v) >= int'(modulus) - 1) return '0;
        return v + digit_t'(1);
    endfunction

    // Next value for a down step. 0 and any value out of range give the top.
    function automatic digit_t step_down(input digit_t v, input int unsigned modulus);
        if (v == '0 || int'(v) >= int'(modulus)) return digit_t'(modulus - 1);
        return v - digit_t'(1);
    endfunction
endpackage

// File: rtl/strobe_sync.sv
// Brings NUM asynchronous strobes into the clk domain, each through STAGES
// flops. Assumes the strobes idle high, so the reset value is 1.
module strobe_sync #(
    parameter int NUM    = 2,
    parameter int STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NUM-1:0] raw,
    output logic [NUM-1:0] synced
);
    localparam int LAST = STAGES - 1;

    for (genvar g = 0; g < NUM; g++) begin : g_chan
        logic [STAGES-1:0] chain;
        // Shift the raw level down the flop chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], raw[g]};
        end
        assign synced[g] = chain[LAST];
    end
endmodule

// File: rtl/strobe_edge_qual.sv
// Finds rising edges of the synchronized strobes and accepts one only while
// the opposite strobe is high. Edges keep being tracked during reset and load,
// so a strobe that was held low through them counts when it next rises.
module strobe_edge_qual (
    input  logic clk,
    input  logic rst_n,
    input  logic up_s,
    input  logic dn_s,
    output logic up_evt,
    output logic dn_evt
);
    logic up_prev, dn_prev;

    // Keep the previous synchronized levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up_prev <= 1'b1;
            dn_prev <= 1'b1;
        end else begin
            up_prev <= up_s;
            dn_prev <= dn_s;
        end
    end

    // Accept a rising edge only while the other strobe is high.
    always_comb begin
        up_evt = up_s & ~up_prev & dn_s;
        dn_evt = dn_s & ~dn_prev & up_s;
    end

    p_evt_needs_other_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (up_evt || dn_evt) |-> (up_s && dn_s));
endmodule

// File: rtl/digit_core.sv
// Holds the digit register. Priority, highest first: master reset, load,
// then a step. An up event and a down event on the same clock cancel.
module digit_core
    import bcd_counter_pkg::*;
#(
    parameter int unsigned MOD = MODULUS
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   mr,
    input  logic   load_n,
    input  digit_t load_value,
    input  logic   up_evt,
    input  logic   dn_evt,
    output digit_t digit
);
    localparam digit_t TOP = digit_t'(MOD - 1);
    digit_t nxt;

    // Choose the next value by priority.
    always_comb begin
        nxt = digit;
        if (mr)                   nxt = '0;
        else if (!load_n)         nxt = load_value;
        else if (up_evt && !dn_evt) nxt = step_up(digit, MOD);
        else if (dn_evt && !up_evt) nxt = step_down(digit, MOD);
    end

    // Update the digit register.
    always_ff @(posedge clk) begin
        if (!rst_n) digit <= '0;
        else        digit <= nxt;
    end

    p_mr_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mr |=> digit == '0);
    p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mr && !load_n) |=> digit == $past(load_value));
    p_up_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mr && load_n && up_evt && !dn_evt && digit == TOP) |=> digit == '0);
    p_down_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mr && load_n && dn_evt && !up_evt && digit == '0) |=> digit == TOP);
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mr && load_n && !up_evt && !dn_evt) |=> $stable(digit));
    p_both_cancel_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!mr && load_n && up_evt && dn_evt) |=> $stable(digit));
    p_stay_in_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && digit <= TOP) |=> digit <= TOP);
    p_out_of_range_up_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!mr && load_n && up_evt && !dn_evt && digit > TOP) |=> digit == '0);
endmodule

// File: rtl/terminal_gate.sv
// Makes the active-low carry and borrow outputs. Each one is the synchronized
// strobe gated by the digit's end state. It is purely combinational, so it can
// feed the next digit's strobe inputs.
module terminal_gate
    import bcd_counter_pkg::*;
#(
    parameter int unsigned MOD = MODULUS
) (
    input  digit_t digit,
    input  logic   up_s,
    input  logic   dn_s,
    output logic   carry_n,
    output logic   borrow_n
);
    localparam digit_t TOP = digit_t'(MOD - 1);

    // Pass each strobe's low phase through only in its end state.
    always_comb begin
        carry_n  = ~((digit == TOP) & ~up_s);
        borrow_n = ~((digit == '0)  & ~dn_s);
    end
endmodule

// File: rtl/bcd_dual_strobe_counter.sv
// Top level: one decimal digit stepped by separate up and down strobes.
// Assumes the unused strobe idles high and that strobe pulses, high and low,
// last longer than the synchronizer depth plus one clock.
module bcd_dual_strobe_counter
    import bcd_counter_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               up_strobe,
    input  logic               down_strobe,
    input  logic               master_reset,
    input  logic               load_n,
    input  logic [DIGIT_W-1:0] load_value,
    output logic [DIGIT_W-1:0] count,
    output logic               carry_n,
    output logic               borrow_n
);
    logic [1:0] synced;
    logic       up_evt, dn_evt;
    digit_t     digit;

    strobe_sync #(.NUM(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw({down_strobe, up_strobe}), .synced(synced));

    strobe_edge_qual u_edge (
        .clk(clk), .rst_n(rst_n), .up_s(synced[0]), .dn_s(synced[1]),
        .up_evt(up_evt), .dn_evt(dn_evt));

    digit_core #(.MOD(MODULUS)) u_core (
        .clk(clk), .rst_n(rst_n), .mr(master_reset), .load_n(load_n),
        .load_value(load_value), .up_evt(up_evt), .dn_evt(dn_evt), .digit(digit));

    terminal_gate #(.MOD(MODULUS)) u_term (
        .digit(digit), .up_s(synced[0]), .dn_s(synced[1]),
        .carry_n(carry_n), .borrow_n(borrow_n));

    assign count = digit;

    p_carry_state_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !carry_n |-> (count == digit_t'(MODULUS - 1)));
    p_borrow_state_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !borrow_n |-> (count == '0));
    p_terminal_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (count >= digit_t'(MODULUS)) |-> (carry_n && borrow_n));
endmodule

// File: tb/bcd_dual_strobe_counter_test.sv
// Directed bench: one task per scenario. Inputs are driven and outputs are
// sampled on the falling clock edge.
module bcd_dual_strobe_counter_test;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       up_strobe = 1, down_strobe = 1, master_reset = 0, load_n = 1;
    logic [3:0] load_value = 0;
    logic [3:0] count;
    logic       carry_n, borrow_n;
    int checks = 0, errors = 0;

    always #5 clk = ~clk;

    bcd_dual_strobe_counter uut (
        .clk(clk), .rst_n(rst_n), .up_strobe(up_strobe), .down_strobe(down_strobe),
        .master_reset(master_reset), .load_n(load_n), .load_value(load_value),
        .count(count), .carry_n(carry_n), .borrow_n(borrow_n));

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic up_pulse();
        up_strobe = 0; tick(4); up_strobe = 1; tick(4);
    endtask

    task automatic down_pulse();
        down_strobe = 0; tick(4); down_strobe = 1; tick(4);
    endtask

    task automatic load(input int v);
        load_value = 4'(v); load_n = 0; tick(1); load_n = 1; tick(1);
    endtask

    task automatic t_reset();
        check("R5 count", count, 0);
        check("R5 carry_n", carry_n, 1);
        check("R5 borrow_n", borrow_n, 1);
    endtask

    task automatic t_count_up();
        for (int i = 1; i <= 10; i++) begin
            up_pulse();
            check("R2 up step", count, i % 10);
            check("R1 range", int'(count < 10), 1);
        end
    endtask

    task automatic t_count_down();
        load(1);
        down_pulse(); check("R3 down to 0", count, 0);
        down_pulse(); check("R3 wrap to 9", count, 9);
        down_pulse(); check("R3 down to 8", count, 8);
    endtask

    task automatic t_timing();
        load(4);
        up_strobe = 0; tick(4); up_strobe = 1;
        tick(2); check("R2 not before third edge", count, 4);
        tick(1); check("R2 after third edge", count, 5);
        tick(2);
    endtask

    task automatic t_other_low();
        load(6);
        down_strobe = 0; tick(4);
        up_pulse(); check("R4 up ignored with down low", count, 6);
        down_strobe = 1; tick(4);
        check("R4 down counts on release", count, 5);
        tick(5); check("R4 hold", count, 5);
    endtask

    task automatic t_mr();
        load(7);
        master_reset = 1; load_n = 0; load_value = 3; up_strobe = 0; tick(4);
        check("R6 mr over load", count, 0);
        up_strobe = 1; tick(4);
        check("R6 mr over strobe", count, 0);
        master_reset = 0; load_n = 1; tick(1);
        check("R6 after release", count, 0);
    endtask

    task automatic t_load();
        load_value = 8; load_n = 0; down_strobe = 0; tick(4);
        down_strobe = 1; tick(4);
        check("R7 load over strobe", count, 8);
        load_n = 1; tick(1);
        check("R7 value kept", count, 8);
    endtask

    task automatic t_carry_borrow();
        load(9);
        check("R8 idle carry", carry_n, 1);
        up_strobe = 0; tick(3);
        check("R8 carry low", carry_n, 0);
        check("R9 borrow idle", borrow_n, 1);
        up_strobe = 1; tick(3);
        check("R8 carry back", carry_n, 1);
        tick(2); check("R2 9 to 0", count, 0);
        down_strobe = 0; tick(3);
        check("R9 borrow low", borrow_n, 0);
        check("R8 carry idle at 0", carry_n, 1);
        down_strobe = 1; tick(5);
        check("R9 borrow back", borrow_n, 1);
        check("R3 0 to 9", count, 9);
        load(5); down_strobe = 0; tick(3);
        check("R9 no borrow at 5", borrow_n, 1);
        down_strobe = 1; tick(5);
    endtask

    task automatic t_held_through();
        load(2);
        up_strobe = 0; tick(3);
        load_value = 3; load_n = 0; tick(2); load_n = 1; tick(2);
        check("R10 loaded while low", count, 3);
        up_strobe = 1; tick(4);
        check("R10 count after load", count, 4);
        down_strobe = 0; tick(3);
        master_reset = 1; tick(2); master_reset = 0; tick(2);
        down_strobe = 1; tick(4);
        check("R10 count after reset", count, 9);
    endtask

    task automatic t_out_of_range();
        load(12); up_pulse(); check("R11 12 up", count, 0);
        load(15); down_pulse(); check("R11 15 down", count, 9);
        load(13); up_strobe = 0; down_strobe = 0; tick(3);
        check("R11 carry quiet", carry_n, 1);
        check("R11 borrow quiet", borrow_n, 1);
        up_strobe = 1; down_strobe = 1; tick(5);
    endtask

    task automatic t_both();
        load(4);
        up_strobe = 0; down_strobe = 0; tick(4);
        up_strobe = 1; down_strobe = 1; tick(4);
        check("R12 both rise", count, 4);
    endtask

    initial begin
        tick(3);
        t_reset();
        rst_n = 1; tick(2);
        t_count_up();
        t_count_down();
        t_timing();
        t_other_low();
        t_mr();
        t_load();
        t_carry_borrow();
        t_held_through();
        t_out_of_range();
        t_both();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule